// File: doc/BRIEF.md
# Link Training Sequencer

This block is the transmitter-side controller that brings a 1, 2 or 4-lane serial display link up to a usable state. After a start pulse it runs a clock-recovery phase and then an equalization phase. In each phase it selects a training pattern for the lane PHYs and waits a fixed interval. It then asks a register-access agent for the receiver's per-lane status and adjust requests. From those it updates each lane's voltage-swing and pre-emphasis drive levels.

The sideband transaction that fetches receiver status is reduced to a request/acknowledge pair. The requester raises `rd_req` and holds it. The agent presents the status on the `rx_*` inputs and pulses `rd_ack` for one cycle, and the sequencer samples the status in that cycle. Training ends in success, or in failure with a reason code. In both cases the pattern returns to none and `done` is raised. Wait intervals are counted in ticks of the block clock, scaled by the parameter `TICKS_PER_US`.

Top module: `lt_seq`

## Requirements
- R1: A `start` pulse seen while idle clears every lane's drive levels to 0 and raises `busy`. It also sets `tps` to code 1, the clock-recovery pattern. The `tps` codes are 0 none, 1 pattern 1, 2 pattern 2, 3 pattern 3 and 4 pattern 4.
- R2: In clock recovery, `rd_req` rises exactly 100*TICKS_PER_US cycles after the edge that accepted `start` or the previous `rd_ack`.
- R3: Once raised, `rd_req` stays high until `rd_ack`. Status inputs are used only in the cycle where `rd_ack` is high.
- R4: Lane i's swing and pre-emphasis are 2-bit fields at bits [2i+1:2i] of the swing and pre-emphasis vectors. A read that continues training loads each active lane with the requested swing. It also loads the requested pre-emphasis, reduced to 3 minus swing when the sum would exceed 3. A read that moves from clock recovery to equalization leaves the levels unchanged.
- R5: Suppose a clock-recovery read in which not all active lanes are done carries the same masked adjust request as the previous read. Suppose this happens for five consecutive such reads. Training then ends with `fail`=1 and `fail_code`=1.
- R6: A clock-recovery read where every active lane reports done switches `tps` to the equalization pattern. Rate codes 0 (1.62 Gb/s) and 1 (2.7 Gb/s) give 2, code 2 (5.4 Gb/s) gives 3, and code 3 (8.1 Gb/s) gives 4.
- R7: In equalization, `rd_req` rises exactly W*TICKS_PER_US cycles after the entering or previous `rd_ack` edge. W is 400, 4000, 8000, 12000 or 16000 for `eq_wait_sel` 0 to 4, and 16000 for 5 to 7.
- R8: An equalization read where every active lane has clock recovery, equalization done and symbol lock, and `rx_aligned` is 1, ends training. The result is `done`=1, `fail`=0, `fail_code`=0 and `tps`=0.
- R9: An equalization read where any active lane lacks clock-recovery done ends training with `fail_code`=2. This holds even if the equalization flags are all good.
- R10: The fifth unsuccessful equalization read ends training with `fail_code`=2.
- R11: `lane_code` 0, 1 and 2 or 3 select lanes {0}, {0,1} and {0..3}. Status and requests of inactive lanes are ignored, and their levels stay 0.
- R12: After reset, `tps`=0, `rd_req`=0, `busy`=0, `done`=0, `fail`=0 and all levels are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin training (accepted when idle) |
| lane_code | input | 2 | Active lane count code |
| rate | input | 2 | Link rate code |
| eq_wait_sel | input | 3 | Equalization interval select |
| rd_req | output | 1 | Status read request |
| rd_ack | input | 1 | Status read acknowledge with data valid |
| rx_cr_done | input | 4 | Per-lane clock recovery done |
| rx_eq_done | input | 4 | Per-lane equalization done |
| rx_sym_lock | input | 4 | Per-lane symbol lock |
| rx_aligned | input | 1 | Inter-lane alignment |
| rx_adj_swing | input | 8 | Requested swing per lane |
| rx_adj_pre | input | 8 | Requested pre-emphasis per lane |
| tps | output | 3 | Training pattern select |
| drv_swing | output | 8 | Drive swing per lane |
| drv_pre | output | 8 | Drive pre-emphasis per lane |
| busy | output | 1 | Training in progress |
| done | output | 1 | Training finished (held until next start) |
| fail | output | 1 | Training ended in failure |
| fail_code | output | 2 | 1 clock recovery error, 2 equalization error |

## Verification
Two decisions can fall on the same acknowledge. One is the fifth identical adjust request arriving in the read where every lane finally reports clock recovery done. The bench provokes it and expects the move to equalization, not the failure. The other is equalization success flags arriving together with a lost clock-recovery bit. The bench expects failure code 2 there. The bench's own model of the counters and lane masks decides every outcome, and the levels, `tps` and result flags are compared at the cycle after each acknowledge.

// File: rtl/lt_seq_pkg.sv
package lt_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CR_WAIT,
    ST_CR_READ,
    ST_EQ_WAIT,
    ST_EQ_READ
  } lt_state_t;

  localparam logic [2:0] PAT_NONE = 3'd0;
  localparam logic [2:0] PAT_1    = 3'd1;
  localparam logic [2:0] PAT_2    = 3'd2;
  localparam logic [2:0] PAT_3    = 3'd3;
  localparam logic [2:0] PAT_4    = 3'd4;

  localparam logic [1:0] ERR_NONE = 2'd0;
  localparam logic [1:0] ERR_CR   = 2'd1;
  localparam logic [1:0] ERR_EQ   = 2'd2;

  localparam int unsigned CR_WAIT_US  = 100;
  localparam int unsigned EQ_WAIT_MAX = 16000;

  function automatic logic [2:0] eq_pattern(input logic [1:0] rate_code);
    case (rate_code)
      2'd2:    eq_pattern = PAT_3;
      2'd3:    eq_pattern = PAT_4;
      default: eq_pattern = PAT_2;
    endcase
  endfunction

  function automatic int unsigned eq_wait_us(input logic [2:0] sel);
    case (sel)
      3'd0:    eq_wait_us = 400;
      3'd1:    eq_wait_us = 4000;
      3'd2:    eq_wait_us = 8000;
      3'd3:    eq_wait_us = 12000;
      default: eq_wait_us = EQ_WAIT_MAX;
    endcase
  endfunction

endpackage

// File: rtl/lt_wait_timer.sv
module lt_wait_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/lt_lane_drive.sv
module lt_lane_drive (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       upd,
  input  logic       active,
  input  logic [1:0] req_sw,
  input  logic [1:0] req_pe,
  output logic [1:0] sw,
  output logic [1:0] pe
);

  logic [1:0] sw_q, sw_d, pe_q, pe_d;
  logic [2:0] req_sum;

  assign req_sum = {1'b0, req_sw} + {1'b0, req_pe};

  always_comb begin
    sw_d = sw_q;
    pe_d = pe_q;
    if (clr || !active) begin
      sw_d = 2'd0;
      pe_d = 2'd0;
    end else if (upd) begin
      sw_d = req_sw;
      pe_d = (req_sum > 3'd3) ? (2'd3 - req_sw) : req_pe;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q <= 2'd0;
      pe_q <= 2'd0;
    end else begin
      sw_q <= sw_d;
      pe_q <= pe_d;
    end
  end

  assign sw = sw_q;
  assign pe = pe_q;

  AST_LEVEL_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, sw_q} + {1'b0, pe_q}) <= 3'd3); // R4

  AST_INACTIVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!active) |-> (sw_q == 2'd0 && pe_q == 2'd0)); // R11

endmodule

// File: rtl/lt_status_eval.sv
module lt_status_eval #(
  parameter int NL = 4
) (
  input  logic [1:0]      lane_code,
  input  logic [NL-1:0]   cr_done,
  input  logic [NL-1:0]   eq_done,
  input  logic [NL-1:0]   sym_lock,
  input  logic            aligned,
  input  logic [2*NL-1:0] adj_sw,
  input  logic [2*NL-1:0] adj_pe,
  output logic [NL-1:0]   mask,
  output logic            all_cr,
  output logic            eq_ok,
  output logic [4*NL-1:0] adj_key
);

  for (genvar i = 0; i < NL; i++) begin : g_lane
    assign mask[i] = (32'(i) < (32'd1 << lane_code));
    assign adj_key[4*i +: 4] = {adj_sw[2*i +: 2], adj_pe[2*i +: 2]} & {4{mask[i]}};
  end

  assign all_cr = ((cr_done & mask) == mask);
  assign eq_ok  = all_cr && ((eq_done & sym_lock & mask) == mask) && aligned;

endmodule

// File: rtl/lt_seq.sv
module lt_seq
  import lt_seq_pkg::*;
#(
  parameter int NL           = 4,
  parameter int TICKS_PER_US = 1,
  parameter int MAX_SAME     = 5,
  parameter int MAX_EQ_TRIES = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      lane_code,
  input  logic [1:0]      rate,
  input  logic [2:0]      eq_wait_sel,
  output logic            rd_req,
  input  logic            rd_ack,
  input  logic [NL-1:0]   rx_cr_done,
  input  logic [NL-1:0]   rx_eq_done,
  input  logic [NL-1:0]   rx_sym_lock,
  input  logic            rx_aligned,
  input  logic [2*NL-1:0] rx_adj_swing,
  input  logic [2*NL-1:0] rx_adj_pre,
  output logic [2:0]      tps,
  output logic [2*NL-1:0] drv_swing,
  output logic [2*NL-1:0] drv_pre,
  output logic            busy,
  output logic            done,
  output logic            fail,
  output logic [1:0]      fail_code
);

  localparam int MAX_CYC = EQ_WAIT_MAX * TICKS_PER_US;
  localparam int TW      = $clog2(MAX_CYC + 1);
  localparam int SW      = $clog2(MAX_SAME + 1);
  localparam int EW      = $clog2(MAX_EQ_TRIES + 1);
  localparam int KW      = 4 * NL;
  localparam logic [TW-1:0] CR_LOAD = TW'(CR_WAIT_US * TICKS_PER_US - 1);

  lt_state_t      state_q, state_d;
  logic [1:0]     lanes_q, lanes_d, rate_q, rate_d;
  logic [2:0]     sel_q, sel_d, tps_q, tps_d;
  logic [SW-1:0]  same_q, same_d, same_n;
  logic [EW-1:0]  tries_q, tries_d, tries_n;
  logic [KW-1:0]  prev_q, prev_d;
  logic           done_q, done_d, fail_q, fail_d;
  logic [1:0]     code_q, code_d;

  logic           tmr_load, tmr_expired;
  logic [TW-1:0]  tmr_val, eq_load;
  logic           lvl_clr, lvl_upd, fin;
  logic [1:0]     fin_err;
  logic [NL-1:0]  lane_mask;
  logic           all_cr, eq_ok;
  logic [KW-1:0]  adj_key;

  assign eq_load = TW'(eq_wait_us(sel_q) * TICKS_PER_US - 1);

  lt_status_eval #(.NL(NL)) u_eval (
    .lane_code (lanes_q),
    .cr_done   (rx_cr_done),
    .eq_done   (rx_eq_done),
    .sym_lock  (rx_sym_lock),
    .aligned   (rx_aligned),
    .adj_sw    (rx_adj_swing),
    .adj_pe    (rx_adj_pre),
    .mask      (lane_mask),
    .all_cr    (all_cr),
    .eq_ok     (eq_ok),
    .adj_key   (adj_key)
  );

  lt_wait_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  for (genvar i = 0; i < NL; i++) begin : g_drive
    lt_lane_drive u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (lvl_clr),
      .upd    (lvl_upd),
      .active (lane_mask[i]),
      .req_sw (rx_adj_swing[2*i +: 2]),
      .req_pe (rx_adj_pre[2*i +: 2]),
      .sw     (drv_swing[2*i +: 2]),
      .pe     (drv_pre[2*i +: 2])
    );
  end

  always_comb begin
    state_d  = state_q;
    lanes_d  = lanes_q;
    rate_d   = rate_q;
    sel_d    = sel_q;
    tps_d    = tps_q;
    same_d   = same_q;
    tries_d  = tries_q;
    prev_d   = prev_q;
    done_d   = done_q;
    fail_d   = fail_q;
    code_d   = code_q;
    tmr_load = 1'b0;
    tmr_val  = CR_LOAD;
    lvl_clr  = 1'b0;
    lvl_upd  = 1'b0;
    fin      = 1'b0;
    fin_err  = ERR_NONE;
    same_n   = (same_q != '0 && adj_key == prev_q) ? same_q + SW'(1) : SW'(1);
    tries_n  = tries_q + EW'(1);

    case (state_q)
      ST_IDLE: if (start) begin
        state_d  = ST_CR_WAIT;
        lanes_d  = lane_code;
        rate_d   = rate;
        sel_d    = eq_wait_sel;
        tps_d    = PAT_1;
        same_d   = '0;
        tries_d  = '0;
        prev_d   = '0;
        done_d   = 1'b0;
        fail_d   = 1'b0;
        code_d   = ERR_NONE;
        lvl_clr  = 1'b1;
        tmr_load = 1'b1;
      end
      ST_CR_WAIT: if (tmr_expired) state_d = ST_CR_READ;
      ST_CR_READ: if (rd_ack) begin
        if (all_cr) begin
          state_d  = ST_EQ_WAIT;
          tps_d    = eq_pattern(rate_q);
          tmr_load = 1'b1;
          tmr_val  = eq_load;
        end else begin
          same_d = same_n;
          prev_d = adj_key;
          if (same_n == SW'(MAX_SAME)) begin
            fin     = 1'b1;
            fin_err = ERR_CR;
          end else begin
            lvl_upd  = 1'b1;
            tmr_load = 1'b1;
            state_d  = ST_CR_WAIT;
          end
        end
      end
      ST_EQ_WAIT: if (tmr_expired) state_d = ST_EQ_READ;
      ST_EQ_READ: if (rd_ack) begin
        if (!all_cr) begin
          fin     = 1'b1;
          fin_err = ERR_EQ;
        end else if (eq_ok) begin
          fin = 1'b1;
        end else begin
          tries_d = tries_n;
          if (tries_n == EW'(MAX_EQ_TRIES)) begin
            fin     = 1'b1;
            fin_err = ERR_EQ;
          end else begin
            lvl_upd  = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = eq_load;
            state_d  = ST_EQ_WAIT;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (fin) begin
      state_d = ST_IDLE;
      tps_d   = PAT_NONE;
      done_d  = 1'b1;
      fail_d  = (fin_err != ERR_NONE);
      code_d  = fin_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lanes_q <= 2'd0;
      rate_q  <= 2'd0;
      sel_q   <= 3'd0;
      tps_q   <= PAT_NONE;
      same_q  <= '0;
      tries_q <= '0;
      prev_q  <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      code_q  <= ERR_NONE;
    end else begin
      state_q <= state_d;
      lanes_q <= lanes_d;
      rate_q  <= rate_d;
      sel_q   <= sel_d;
      tps_q   <= tps_d;
      same_q  <= same_d;
      tries_q <= tries_d;
      prev_q  <= prev_d;
      done_q  <= done_d;
      fail_q  <= fail_d;
      code_q  <= code_d;
    end
  end

  assign rd_req    = (state_q == ST_CR_READ) || (state_q == ST_EQ_READ);
  assign busy      = (state_q != ST_IDLE);
  assign tps       = tps_q;
  assign done      = done_q;
  assign fail      = fail_q;
  assign fail_code = code_q;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req); // R3

  AST_REQ_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req) |-> $past(tmr_expired)); // R2

  AST_CR_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CR_WAIT || state_q == ST_CR_READ) |-> tps == PAT_1); // R1

  AST_EQ_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EQ_WAIT || state_q == ST_EQ_READ) |-> tps == eq_pattern(rate_q)); // R6

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tps == PAT_NONE && !busy && !rd_req)); // R8

  AST_FAIL_CODED: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (done && fail_code != ERR_NONE)); // R5

endmodule

// File: tb/lt_seq_test.sv
module lt_seq_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] lane_code = 2'd0;
  logic [1:0] rate = 2'd0;
  logic [2:0] eq_wait_sel = 3'd0;
  logic       rd_ack = 1'b0;
  logic [3:0] rx_cr_done = 4'd0, rx_eq_done = 4'd0, rx_sym_lock = 4'd0;
  logic       rx_aligned = 1'b0;
  logic [7:0] rx_adj_swing = 8'd0, rx_adj_pre = 8'd0;
  logic       rd_req, busy, done, fail;
  logic [2:0] tps;
  logic [7:0] drv_swing, drv_pre;
  logic [1:0] fail_code;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [3:0] s_cr [16];
  logic [3:0] s_eq [16];
  logic [3:0] s_lk [16];
  logic       s_al [16];
  logic [7:0] s_sw [16];
  logic [7:0] s_pe [16];

  always #4 clk = ~clk;

  lt_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .lane_code(lane_code), .rate(rate),
    .eq_wait_sel(eq_wait_sel), .rd_req(rd_req), .rd_ack(rd_ack),
    .rx_cr_done(rx_cr_done), .rx_eq_done(rx_eq_done), .rx_sym_lock(rx_sym_lock),
    .rx_aligned(rx_aligned), .rx_adj_swing(rx_adj_swing), .rx_adj_pre(rx_adj_pre),
    .tps(tps), .drv_swing(drv_swing), .drv_pre(drv_pre), .busy(busy), .done(done),
    .fail(fail), .fail_code(fail_code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] mask_of(input logic [1:0] lc);
    return (lc == 2'd0) ? 4'b0001 : (lc == 2'd1) ? 4'b0011 : 4'b1111;
  endfunction

  function automatic int eq_us(input logic [2:0] sel);
    case (sel)
      3'd0: return 400;
      3'd1: return 4000;
      3'd2: return 8000;
      3'd3: return 12000;
      default: return 16000;
    endcase
  endfunction

  function automatic logic [2:0] eq_pat(input logic [1:0] r);
    return (r == 2'd3) ? 3'd4 : (r == 2'd2) ? 3'd3 : 3'd2;
  endfunction

  task automatic set_resp(input int i, input logic [3:0] cr, input logic [3:0] eq,
                          input logic [3:0] lk, input logic al,
                          input logic [7:0] sw, input logic [7:0] pe);
    s_cr[i] = cr; s_eq[i] = eq; s_lk[i] = lk; s_al[i] = al; s_sw[i] = sw; s_pe[i] = pe;
  endtask

  task automatic fill_all(input logic [3:0] cr, input logic [3:0] eq, input logic [3:0] lk,
                          input logic al, input logic [7:0] sw, input logic [7:0] pe);
    for (int i = 0; i < 16; i++) set_resp(i, cr, eq, lk, al, sw, pe);
  endtask

  task automatic run_train(input logic [1:0] lc, input logic [1:0] rt,
                           input logic [2:0] sel, input int nresp);
    logic [3:0] m;
    logic [7:0] esw, epe, psw, ppe, ksw, kpe, m2;
    int phase, same, tries, n, cyc, ew, idx;
    logic [1:0] s, p;
    m = mask_of(lc);
    m2 = {{2{m[3]}}, {2{m[2]}}, {2{m[1]}}, {2{m[0]}}};
    esw = 8'd0; epe = 8'd0; psw = 8'd0; ppe = 8'd0;
    phase = 0; same = 0; tries = 0; n = 0;
    lane_code = lc; rate = rt; eq_wait_sel = sel; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    chk(busy && tps == 3'd1 && drv_swing == 8'd0 && drv_pre == 8'd0, "R1 start state",
        {busy, tps, drv_swing}, {1'b1, 3'd1, 8'd0});
    forever begin
      cyc = 0;
      while (!rd_req && cyc <= 20000) begin
        @(posedge clk); #1; cyc++;
      end
      ew = (phase == 0) ? 100 : eq_us(sel);
      chk(cyc == ew, (phase == 0) ? "R2 cr wait" : "R7 eq wait", cyc, ew);
      if (!rd_req) return;
      chk(tps == ((phase == 0) ? 3'd1 : eq_pat(rt)), (phase == 0) ? "R1 cr pattern" : "R6 eq pattern",
          tps, (phase == 0) ? 3'd1 : eq_pat(rt));
      repeat ($urandom_range(3)) begin
        @(posedge clk); #1;
        chk(rd_req, "R3 request held", rd_req, 1);
      end
      idx = (n < nresp) ? n : nresp - 1;
      rx_cr_done = s_cr[idx]; rx_eq_done = s_eq[idx]; rx_sym_lock = s_lk[idx];
      rx_aligned = s_al[idx]; rx_adj_swing = s_sw[idx]; rx_adj_pre = s_pe[idx];
      rd_ack = 1'b1;
      @(posedge clk); #1 rd_ack = 1'b0;
      n++;
      rx_cr_done = 4'($urandom); rx_eq_done = 4'($urandom); rx_sym_lock = 4'($urandom);
      rx_adj_swing = 8'($urandom); rx_adj_pre = 8'($urandom); rx_aligned = 1'($urandom);
      if (phase == 0) begin
        if ((s_cr[idx] & m) == m) begin
          phase = 1;
          chk(busy && !done, "R6 enter eq", {busy, done}, 2'b10);
          chk(drv_swing == esw && drv_pre == epe, "R4 levels kept", {drv_swing, drv_pre}, {esw, epe});
          continue;
        end
        ksw = s_sw[idx] & m2; kpe = s_pe[idx] & m2;
        same = (same > 0 && ksw == psw && kpe == ppe) ? same + 1 : 1;
        psw = ksw; ppe = kpe;
        if (same == 5) begin
          chk(done && fail && fail_code == 2'd1 && tps == 3'd0, "R5 cr error",
              {done, fail, fail_code, tps}, {1'b1, 1'b1, 2'd1, 3'd0});
          return;
        end
      end else begin
        if ((s_cr[idx] & m) != m) begin
          chk(done && fail && fail_code == 2'd2 && tps == 3'd0, "R9 cr lost",
              {done, fail, fail_code, tps}, {1'b1, 1'b1, 2'd2, 3'd0});
          return;
        end
        if (((s_eq[idx] & s_lk[idx] & m) == m) && s_al[idx]) begin
          chk(done && !fail && fail_code == 2'd0 && tps == 3'd0 && !busy, "R8 success",
              {done, fail, fail_code, tps}, {1'b1, 1'b0, 2'd0, 3'd0});
          chk(drv_swing == esw && drv_pre == epe, "R11 final levels", {drv_swing, drv_pre}, {esw, epe});
          return;
        end
        tries++;
        if (tries == 5) begin
          chk(done && fail && fail_code == 2'd2, "R10 eq exhausted",
              {done, fail, fail_code}, {1'b1, 1'b1, 2'd2});
          return;
        end
      end
      for (int l = 0; l < 4; l++) begin
        s = s_sw[idx][2*l +: 2]; p = s_pe[idx][2*l +: 2];
        if (32'(s) + 32'(p) > 3) p = 2'd3 - s;
        esw[2*l +: 2] = m[l] ? s : 2'd0;
        epe[2*l +: 2] = m[l] ? p : 2'd0;
      end
      chk(drv_swing == esw && drv_pre == epe, "R4 levels update", {drv_swing, drv_pre}, {esw, epe});
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    chk(tps == 3'd0 && !rd_req && !busy && !done && !fail && drv_swing == 8'd0 && drv_pre == 8'd0,
        "R12 reset state", {tps, rd_req, busy, done, fail}, 0);

    // 4 lanes, top rate, 16 ms wait; clamp of swing 3 + pre 2
    fill_all(4'hF, 4'hF, 4'hF, 1'b1, 8'h00, 8'h00);
    set_resp(0, 4'h7, 4'h0, 4'h0, 1'b0, 8'b11_01_10_11, 8'b11_11_01_10);
    run_train(2'd2, 2'd3, 3'd4, 3);

    // identical requests on 2 lanes: fifth read fails (R5)
    fill_all(4'b1101, 4'h0, 4'h0, 1'b0, 8'h05, 8'h02);
    run_train(2'd1, 2'd0, 3'd0, 16);

    // fifth identical request arrives with all lanes done: moves on (R5/R6 same cycle)
    fill_all(4'h0, 4'hF, 4'hF, 1'b1, 8'h05, 8'h02);
    set_resp(4, 4'h3, 4'h0, 4'h0, 1'b0, 8'h05, 8'h02);
    run_train(2'd1, 2'd1, 3'd1, 16);

    // equalization never converges: R10, 5.4 rate pattern
    fill_all(4'hF, 4'hF, 4'h7, 1'b1, 8'h12, 8'h21);
    run_train(2'd3, 2'd2, 3'd0, 16);

    // clock recovery lost together with good equalization flags: R9
    fill_all(4'hF, 4'hF, 4'hF, 1'b1, 8'h00, 8'h00);
    set_resp(1, 4'hB, 4'hF, 4'hF, 1'b1, 8'h00, 8'h00);
    run_train(2'd2, 2'd0, 3'd2, 16);

    // one lane; inactive lanes carry junk that must be ignored (R11)
    fill_all(4'b0001, 4'b0001, 4'b0001, 1'b1, 8'hFF, 8'hFF);
    set_resp(0, 4'b1110, 4'h0, 4'h0, 1'b0, 8'hFD, 8'hFE);
    run_train(2'd0, 2'd1, 3'd3, 16);
    chk(drv_swing[7:2] == 6'd0 && drv_pre[7:2] == 6'd0, "R11 inactive lanes zero",
        {drv_swing, drv_pre}, {6'd0, 2'd1, 6'd0, 2'd2});

    // selector above 4 maps to 16 ms (R7)
    fill_all(4'hF, 4'hF, 4'hF, 1'b1, 8'h00, 8'h00);
    run_train(2'd1, 2'd2, 3'd7, 16);

    // constrained random runs, short equalization wait
    for (int t = 0; t < 10; t++) begin
      for (int i = 0; i < 16; i++) begin
        if (i < 6)
          set_resp(i, ($urandom_range(3) == 0) ? 4'hF : 4'($urandom), 4'($urandom | 4'h8),
                   4'($urandom | 4'h8), 1'($urandom), 8'($urandom), 8'($urandom));
        else
          set_resp(i, 4'hF, 4'hF, 4'hF, 1'b1, 8'($urandom), 8'($urandom));
      end
      run_train(2'($urandom), 2'($urandom), 3'd0, 16);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule